// File: doc/BRIEF.md
# Interrupt Source Controller with Level and Message Sources

This block keeps the state of a parameterised group of interrupt sources (16 by default) and turns their activity into interrupt offers for a downstream presenter. Each source is either a level source or a message source. Which one it is comes from a build-time map, so reset never changes it. Every source holds a target server number, a priority, a saved priority and four status bits. A priority of 0xFF masks the source. Interrupt numbers are the source index plus a configurable base number.

Message sources fire on a rising edge of their input. A level source follows its input level and is offered while it is asserted, unmasked and not yet sent. The presenter can reject an offer, signal end of interrupt, or ask for a resend. Status bits hold a rejected or masked interrupt so it can be replayed later and is not lost. Offers leave one at a time on a valid/ready port. Pending work is handled in ascending source index, one source per cycle, and handling pauses while an offer waits for acceptance. A combinational peek port shows the state of one source.

Top module: `irq_source_ctl`

## Requirements
- R1: After reset every source has priority 0xFF, saved priority 0xFF, server 0 and status 0, and no offer is valid. The peek_stat encoding is: bit0 asserted, bit1 sent, bit2 rejected, bit3 masked-pending.
- R2: A rising edge on msi_in of an unmasked message source produces exactly one offer. The offer carries number BASE + index, the source priority and the source server.
- R3: A rising edge on a masked message source sets masked-pending and produces no offer.
- R4: A configuration write stores server, priority and saved priority, then re-evaluates the source. A message source with masked-pending and a new priority other than 0xFF clears the bit and is offered. A level source applies the level rule.
- R5: A level source is offered only when unmasked, asserted and not sent, and the offer sets sent. The asserted bit follows lsi_lvl.
- R6: A reject sets rejected on a message source and clears sent on a level source. Neither produces a new offer by itself.
- R7: An EOI clears sent on a level source and leaves the status of a message source unchanged.
- R8: A resend clears rejected on every message source that has it set and re-offers that source when it is unmasked. It re-applies the level rule to every level source.
- R9: A reject or EOI number whose distance above BASE is not below the source count, including numbers under BASE, changes no source.
- R10: At most one offer is outstanding. Its server, number and priority stay stable until ofr_ready is seen high.
- R11: Message events that arrive in the same cycle are offered in ascending source index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_in | input | NUM_SRC | Event inputs; a rising edge is a message event |
| lsi_lvl | input | NUM_SRC | Level inputs of level sources |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Source index to configure |
| cfg_server | input | SRV_W | New target server |
| cfg_prio | input | 8 | New priority (0xFF masks) |
| cfg_saved | input | 8 | New saved priority |
| rej_valid | input | 1 | Reject request strobe |
| rej_num | input | NUM_W | Interrupt number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Interrupt number being completed |
| resend_req | input | 1 | Replay request for all sources |
| ofr_valid | output | 1 | Offer valid |
| ofr_ready | input | 1 | Presenter accepts the offer |
| ofr_server | output | SRV_W | Offer target server |
| ofr_num | output | NUM_W | Offer interrupt number |
| ofr_prio | output | 8 | Offer priority |
| peek_idx | input | IDX_W | Source selected for the peek port |
| peek_server | output | SRV_W | Server of peeked source |
| peek_prio | output | 8 | Priority of peeked source |
| peek_saved | output | 8 | Saved priority of peeked source |
| peek_stat | output | 4 | Status bits of peeked source |

## Verification
Message sources get a single edge while unmasked and a single edge while masked. These two cases separate an immediate offer from a masked-pending hold, and a later unmasking write shows the held event is replayed. A level source is held high through a full sequence: offer, EOI, resend, reject and resend. This shows the sent bit, and not the level, decides whether a second offer appears. Simultaneous edges on two sources show the index ordering. An offer held against a low ready shows the handshake keeps its payload. Reject and EOI numbers just outside the window show that no index aliases into range.

// File: rtl/irqsrc_pkg.sv
package irqsrc_pkg;
  localparam logic [7:0] PRIO_OFF = 8'hFF;

  typedef struct packed {
    logic mpend;  // bit3 masked-pending
    logic rejd;   // bit2 rejected
    logic sent;   // bit1 sent
    logic asrt;   // bit0 asserted
  } src_stat_t;

  // interrupt number -> source index (wraps when below base)
  function automatic int unsigned num_to_idx(int unsigned num, int unsigned base);
    return num - base;
  endfunction

  function automatic int unsigned idx_to_num(int unsigned idx, int unsigned base);
    return idx + base;
  endfunction

  function automatic logic idx_in_window(int unsigned idx, int unsigned count);
    return idx < count;
  endfunction
endpackage

// File: rtl/irqsrc_pick.sv
module irqsrc_pick #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/irqsrc_slot.sv
module irqsrc_slot
  import irqsrc_pkg::*;
#(
  parameter bit IS_LSI = 1'b0,
  parameter int SRV_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_hit,
  input  logic [SRV_W-1:0] cfg_server,
  input  logic [7:0]       cfg_prio,
  input  logic [7:0]       cfg_saved,
  input  logic             msi_rise,
  input  logic             lvl,
  input  logic             rej_hit,
  input  logic             eoi_hit,
  input  logic             rsnd_all,
  input  logic             take,
  output logic             work,
  output logic             go,
  output logic [SRV_W-1:0] server,
  output logic [7:0]       prio,
  output logic [7:0]       saved,
  output src_stat_t        stat
);
  logic evt, cfgk, rsn;
  logic unmasked;
  logic unused_ok;

  assign unmasked  = (prio != PRIO_OFF);
  assign work      = evt | cfgk | rsn;
  assign unused_ok = IS_LSI ? 1'b0 : (lvl ^ eoi_hit);

  always_comb begin
    if (IS_LSI)      go = cfgk & unmasked & stat.asrt & ~stat.sent;
    else if (evt)    go = unmasked;
    else if (cfgk)   go = stat.mpend & unmasked;
    else             go = rsn & stat.rejd & unmasked;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      server <= '0;
      prio   <= PRIO_OFF;
      saved  <= PRIO_OFF;
      stat   <= '0;
      evt    <= 1'b0;
      cfgk   <= 1'b0;
      rsn    <= 1'b0;
    end else begin
      if (IS_LSI) begin
        if (take) cfgk <= 1'b0;
        stat.asrt <= lvl;
        if ((lvl != stat.asrt) || rsnd_all || msi_rise) cfgk <= 1'b1;
        if (rej_hit || eoi_hit) stat.sent <= 1'b0;
        if (take && go) stat.sent <= 1'b1;
      end else begin
        if (take) begin
          if (evt) begin
            evt <= 1'b0;
            if (!unmasked) stat.mpend <= 1'b1;
          end else if (cfgk) begin
            cfgk <= 1'b0;
            if (go) stat.mpend <= 1'b0;
          end else begin
            rsn       <= 1'b0;
            stat.rejd <= 1'b0;
          end
        end
        if (msi_rise) evt <= 1'b1;
        if (rsnd_all) rsn <= 1'b1;
        if (rej_hit) stat.rejd <= 1'b1;
      end
      if (cfg_hit) begin
        server <= cfg_server;
        prio   <= cfg_prio;
        saved  <= cfg_saved;
        cfgk   <= 1'b1;
      end
    end
  end

  // R5: a level offer leaves the sent bit set
  a_r5_sent_on_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_LSI && take && go) |=> stat.sent);
  // R3: masked-pending only rises while the source was masked
  a_r3_mpend_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat.mpend) |-> ($past(prio) == PRIO_OFF));
  // R6: reject on a message source records rejected
  a_r6_reject_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_LSI && rej_hit) |=> stat.rejd);
endmodule

// File: rtl/irq_source_ctl.sv
module irq_source_ctl
  import irqsrc_pkg::*;
#(
  parameter int                   NUM_SRC = 16,
  parameter int                   NUM_W   = 12,
  parameter int                   SRV_W   = 8,
  parameter int unsigned          BASE    = 64,
  parameter logic [NUM_SRC-1:0]   LSI_MAP = 16'hF000,
  localparam int                  IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] msi_in,
  input  logic [NUM_SRC-1:0] lsi_lvl,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [SRV_W-1:0]   cfg_server,
  input  logic [7:0]         cfg_prio,
  input  logic [7:0]         cfg_saved,
  input  logic               rej_valid,
  input  logic [NUM_W-1:0]   rej_num,
  input  logic               eoi_valid,
  input  logic [NUM_W-1:0]   eoi_num,
  input  logic               resend_req,
  output logic               ofr_valid,
  input  logic               ofr_ready,
  output logic [SRV_W-1:0]   ofr_server,
  output logic [NUM_W-1:0]   ofr_num,
  output logic [7:0]         ofr_prio,
  input  logic [IDX_W-1:0]   peek_idx,
  output logic [SRV_W-1:0]   peek_server,
  output logic [7:0]         peek_prio,
  output logic [7:0]         peek_saved,
  output logic [3:0]         peek_stat
);
  logic [NUM_SRC-1:0] msi_q, msi_rise;
  logic [NUM_SRC-1:0] work, go, take;
  logic [SRV_W-1:0]   srv_a  [NUM_SRC];
  logic [7:0]         prio_a [NUM_SRC];
  logic [7:0]         saved_a[NUM_SRC];
  src_stat_t          stat_a [NUM_SRC];

  int unsigned rej_idx, eoi_idx;
  logic        rej_ok, eoi_ok;
  logic        idle, pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic        offer_fire;

  assign rej_idx  = num_to_idx(32'(rej_num), BASE);
  assign eoi_idx  = num_to_idx(32'(eoi_num), BASE);
  assign rej_ok   = rej_valid & idx_in_window(rej_idx, NUM_SRC);
  assign eoi_ok   = eoi_valid & idx_in_window(eoi_idx, NUM_SRC);
  assign msi_rise = msi_in & ~msi_q;
  assign idle     = ~ofr_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) msi_q <= '0;
    else        msi_q <= msi_in;
  end

  irqsrc_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .req(work), .any(pick_any), .idx(pick_idx)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign take[i] = idle & pick_any & (pick_idx == IDX_W'(i));
    irqsrc_slot #(.IS_LSI(LSI_MAP[i]), .SRV_W(SRV_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_hit   (cfg_we && (cfg_idx == IDX_W'(i))),
      .cfg_server(cfg_server),
      .cfg_prio  (cfg_prio),
      .cfg_saved (cfg_saved),
      .msi_rise  (msi_rise[i]),
      .lvl       (lsi_lvl[i]),
      .rej_hit   (rej_ok && (rej_idx == i)),
      .eoi_hit   (eoi_ok && (eoi_idx == i)),
      .rsnd_all  (resend_req),
      .take      (take[i]),
      .work      (work[i]),
      .go        (go[i]),
      .server    (srv_a[i]),
      .prio      (prio_a[i]),
      .saved     (saved_a[i]),
      .stat      (stat_a[i])
    );
  end

  assign offer_fire = |(take & go);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofr_valid  <= 1'b0;
      ofr_server <= '0;
      ofr_num    <= '0;
      ofr_prio   <= PRIO_OFF;
    end else if (ofr_valid) begin
      if (ofr_ready) ofr_valid <= 1'b0;
    end else if (offer_fire) begin
      ofr_valid  <= 1'b1;
      ofr_server <= srv_a[pick_idx];
      ofr_prio   <= prio_a[pick_idx];
      ofr_num    <= NUM_W'(idx_to_num(32'(pick_idx), BASE));
    end
  end

  always_comb begin
    peek_server = '0;
    peek_prio   = PRIO_OFF;
    peek_saved  = PRIO_OFF;
    peek_stat   = '0;
    if (32'(peek_idx) < NUM_SRC) begin
      peek_server = srv_a[peek_idx];
      peek_prio   = prio_a[peek_idx];
      peek_saved  = saved_a[peek_idx];
      peek_stat   = stat_a[peek_idx];
    end
  end

  // R10: an outstanding offer holds its payload until accepted
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ofr_valid && !ofr_ready) |=> (ofr_valid && $stable(ofr_num)
      && $stable(ofr_prio) && $stable(ofr_server)));
  // R2: an offer never carries the mask priority
  a_r2_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    ofr_valid |-> (ofr_prio != PRIO_OFF));
  // R2: offered numbers lie inside the source window
  a_r2_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    ofr_valid |-> ((32'(ofr_num) - BASE) < NUM_SRC));
  // R10: at most one source is taken per cycle
  a_r10_single_take: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));
endmodule

// File: tb/irq_source_ctl_test.sv
module irq_source_ctl_test;
  localparam int N = 16, NW = 12, SW = 8, IW = 4;
  localparam int BASE = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] msi_in = '0, lsi_lvl = '0;
  logic cfg_we = 0; logic [IW-1:0] cfg_idx = '0; logic [SW-1:0] cfg_server = '0;
  logic [7:0] cfg_prio = '0, cfg_saved = '0;
  logic rej_valid = 0, eoi_valid = 0, resend_req = 0, ofr_ready = 0;
  logic [NW-1:0] rej_num = '0, eoi_num = '0;
  logic ofr_valid; logic [SW-1:0] ofr_server; logic [NW-1:0] ofr_num; logic [7:0] ofr_prio;
  logic [IW-1:0] peek_idx = '0; logic [SW-1:0] peek_server;
  logic [7:0] peek_prio, peek_saved; logic [3:0] peek_stat;

  int checks = 0, fails = 0; bit done = 0;

  always #10 clk = ~clk;

  irq_source_ctl uut (.*);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(int idx, int srv, int pr, int sv);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_server = SW'(srv); cfg_prio = 8'(pr); cfg_saved = 8'(sv);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic pulse_msi(logic [N-1:0] m);
    @(negedge clk); msi_in = m; @(negedge clk); msi_in = '0;
  endtask

  task automatic send_rej(int num);
    @(negedge clk); rej_valid = 1; rej_num = NW'(num); @(negedge clk); rej_valid = 0;
  endtask

  task automatic send_eoi(int num);
    @(negedge clk); eoi_valid = 1; eoi_num = NW'(num); @(negedge clk); eoi_valid = 0;
  endtask

  task automatic send_resend();
    @(negedge clk); resend_req = 1; @(negedge clk); resend_req = 0;
  endtask

  task automatic wait_offer(string tag, int num, int pr, int srv);
    int k = 0;
    while (!ofr_valid && k < 40) begin @(negedge clk); k++; end
    check({tag, " offer valid"}, int'(ofr_valid), 1);
    check({tag, " number"}, int'(ofr_num), num);
    check({tag, " priority"}, int'(ofr_prio), pr);
    check({tag, " server"}, int'(ofr_server), srv);
    ofr_ready = 1; @(negedge clk); ofr_ready = 0;
  endtask

  task automatic expect_none(string tag, int cycles);
    int seen = 0;
    for (int c = 0; c < cycles; c++) begin @(negedge clk); if (ofr_valid) seen = 1; end
    check({tag, " no offer"}, seen, 0);
  endtask

  task automatic peek(string tag, int idx, int st);
    peek_idx = IW'(idx); #1;
    check({tag, " status"}, int'(peek_stat), st);
  endtask

  task automatic t_reset();  // R1
    @(negedge clk);
    check("R1 ofr_valid", int'(ofr_valid), 0);
    for (int i = 0; i < N; i += 5) begin
      peek_idx = IW'(i); #1;
      check("R1 prio", int'(peek_prio), 8'hFF);
      check("R1 saved", int'(peek_saved), 8'hFF);
      check("R1 status", int'(peek_stat), 0);
    end
  endtask

  task automatic t_masked_then_unmask();  // R3, R4
    pulse_msi(16'h0040);
    expect_none("R3 masked msi", 6);
    peek("R3 masked-pending", 6, 4'b1000);
    cfg(6, 3, 9, 17);
    wait_offer("R4 unmask replay", BASE + 6, 9, 3);
    peek("R4 cleared", 6, 0);
    check("R4 saved stored", int'(peek_saved), 17);
  endtask

  task automatic t_msi_hold();  // R2, R10
    cfg(4, 11, 2, 2);
    expect_none("R4 msi cfg without pending", 4);
    pulse_msi(16'h0010);
    for (int c = 0; c < 8 && !ofr_valid; c++) @(negedge clk);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check("R10 held valid", int'(ofr_valid), 1);
      check("R10 held number", int'(ofr_num), BASE + 4);
    end
    wait_offer("R2 msi offer", BASE + 4, 2, 11);
    expect_none("R2 single offer", 5);
  endtask

  task automatic t_order();  // R11
    cfg(2, 1, 6, 6);
    cfg(5, 2, 1, 1);
    pulse_msi(16'h0024);
    wait_offer("R11 first", BASE + 2, 6, 1);
    wait_offer("R11 second", BASE + 5, 1, 2);
  endtask

  task automatic t_level();  // R5, R6, R7, R8
    cfg(12, 7, 3, 3);
    expect_none("R5 level low", 4);
    @(negedge clk); lsi_lvl[12] = 1;
    wait_offer("R5 level offer", BASE + 12, 3, 7);
    peek("R5 sent", 12, 4'b0011);
    expect_none("R5 no repeat while sent", 6);
    send_eoi(BASE + 12);
    peek("R7 eoi clears sent", 12, 4'b0001);
    expect_none("R7 eoi no offer", 4);
    send_resend();
    wait_offer("R8 level resend", BASE + 12, 3, 7);
    send_rej(BASE + 12);
    peek("R6 level reject", 12, 4'b0001);
    expect_none("R6 level reject no offer", 4);
    @(negedge clk); lsi_lvl[12] = 0;
    send_resend();
    expect_none("R8 deasserted resend", 20);
    peek("R5 deasserted", 12, 0);
  endtask

  task automatic t_reject_msi();  // R6, R7, R8, R9
    send_rej(BASE + 4);
    peek("R6 msi reject", 4, 4'b0100);
    expect_none("R6 msi reject no offer", 4);
    send_eoi(BASE + 4);
    peek("R7 msi eoi no effect", 4, 4'b0100);
    send_rej(BASE + N);
    send_rej(BASE - 1);
    send_eoi(BASE + N);
    peek("R9 out of window src0", 0, 0);
    peek("R9 out of window src15", 15, 0);
    send_resend();
    wait_offer("R8 msi resend", BASE + 4, 2, 11);
    peek("R8 rejected cleared", 4, 0);
    expect_none("R8 single replay", 24);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_masked_then_unmask();
    t_msi_hold();
    t_order();
    t_level();
    t_reject_msi();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule